// File: doc/BRIEF.md
# USB Frame Timer and Counter

This block sets the frame timing of a USB host controller. It runs on a system clock and is stepped by a single-cycle bit-time enable that comes from a 12 MHz source. A frame-remaining down-counter counts enabled ticks. When it reaches zero it reloads from a programmable 14-bit frame interval, and a 16-bit frame number then advances by one. Each reload produces a start-of-frame pulse. A separate pulse marks every change of the frame number's top bit.

Software programs an interval register and a periodic-start register. The interval register holds three fields: the frame length minus one, a largest-data-packet value that is latched at each frame start, and a toggle bit. The toggle bit is copied into the remaining counter's toggle at every reload, so software can tell when a new interval has taken effect. The block also raises a periodic-start pulse once per frame, when the remaining count drops below the programmed start value.

The counter runs only in the operational functional state. Entering that state loads the counter from the interval. In any other state the counter and the frame number hold their values.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, remain_o, remain_tgl_o, frame_num_o, ldp_o, pstart_o and all pulse outputs are 0, and ival_o reads the reset interval 11999 (0x00002EDF).
- R2: A write with ival_we_i stores wdata_i[13:0] as the frame interval, wdata_i[29:16] as the largest-data-packet value and wdata_i[31] as the interval toggle. ival_o returns them in the same positions and reads 0 elsewhere. A write with pstart_we_i stores wdata_i[13:0] as the periodic start value on pstart_o.
- R3: In the cycle state_i becomes operational (encoding 2'b10, the others being 2'b00 reset, 2'b01 resume and 2'b11 suspend), the counter loads the interval and the toggle, whatever bit_en_i is. This load leaves frame_num_o unchanged and raises no start-of-frame pulse.
- R4: While operational, each enabled tick with a nonzero remaining count lowers remain_o by exactly 1.
- R5: An enabled tick with remain_o at 0 reloads remain_o from the interval and remain_tgl_o from the interval toggle, increments frame_num_o, latches the largest-data-packet value onto ldp_o, and makes sof_o high for one cycle.
- R6: In steady operation, consecutive start-of-frame pulses are interval+1 enabled ticks apart.
- R7: frame_num_o rolls over from 0xFFFF to 0x0000.
- R8: fno_o is high for one cycle, together with sof_o, exactly when bit 15 of frame_num_o changes (0x7FFF to 0x8000 and 0xFFFF to 0x0000).
- R9: pstart_hit_o is high for one cycle after the enabled tick that takes the remaining count from the periodic start value to one below it. With a start value of 0 it never fires.
- R10: When state_i is not operational, or bit_en_i is low, remain_o, remain_tgl_o and frame_num_o hold, and no pulse output fires.
- R11: An interval write in mid-frame does not change the running count. The new interval and toggle appear only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle bit-time tick enable |
| state_i | input | 2 | Functional state of the controller |
| ival_we_i | input | 1 | Write strobe for the interval register |
| pstart_we_i | input | 1 | Write strobe for the periodic start register |
| wdata_i | input | 32 | Write data |
| ival_o | output | 32 | Interval register read value |
| pstart_o | output | 14 | Periodic start read value |
| remain_o | output | 14 | Frame remaining count |
| remain_tgl_o | output | 1 | Toggle copied at the last reload |
| frame_num_o | output | 16 | Frame number |
| ldp_o | output | 14 | Largest-data-packet value latched at frame start |
| sof_o | output | 1 | Start-of-frame pulse |
| fno_o | output | 1 | Frame-number top-bit change pulse |
| pstart_hit_o | output | 1 | Periodic start threshold pulse |

## Verification
The bench runs a six-tick frame through its pulses, one step at a time. It catches an off-by-one reload, which would stretch or shorten the frame, and a threshold compare that fires a cycle early. It writes a new interval mid-frame, so a design that loads the interval straight into the counter or copies the toggle early shows the wrong count at once. A one-tick-per-frame run walks the frame number through its full range, to catch an overflow pulse that misses the 0x7FFF-to-0x8000 change or the wrap. The entry load and the suspend hold are checked against designs that also bump the frame number on entry, or keep counting outside the operational state.

// File: rtl/usb_ft_pkg.sv
package usb_ft_pkg;
  typedef enum logic [1:0] {
    FS_RESET   = 2'b00,
    FS_RESUME  = 2'b01,
    FS_OPER    = 2'b10,
    FS_SUSPEND = 2'b11
  } fstate_e;

  localparam int unsigned REG_W   = 32;
  localparam int unsigned TGL_BIT = 31;
  localparam int unsigned LDP_LSB = 16;
endpackage

// File: rtl/ft_regs.sv
module ft_regs
  import usb_ft_pkg::*;
#(
  parameter int unsigned FI_W     = 14,
  parameter int unsigned FI_RESET = 11999
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ival_we_i,
  input  logic             pstart_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [FI_W-1:0]  fi_o,
  output logic [FI_W-1:0]  ldp_o,
  output logic             fit_o,
  output logic [FI_W-1:0]  ps_o,
  output logic [REG_W-1:0] ival_rd_o
);
  localparam int unsigned LDP_MSB = LDP_LSB + FI_W - 1;

  logic [FI_W-1:0] fi_q, ldp_q, ps_q;
  logic            fit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fi_q  <= FI_W'(FI_RESET);
      ldp_q <= '0;
      fit_q <= 1'b0;
    end else if (ival_we_i) begin
      fi_q  <= wdata_i[FI_W-1:0];
      ldp_q <= wdata_i[LDP_MSB:LDP_LSB];
      fit_q <= wdata_i[TGL_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ps_q <= '0;
    else if (pstart_we_i) ps_q <= wdata_i[FI_W-1:0];
  end

  // Readback: fields in write positions, unused bits zero
  always_comb begin
    ival_rd_o                  = '0;
    ival_rd_o[FI_W-1:0]        = fi_q;
    ival_rd_o[LDP_MSB:LDP_LSB] = ldp_q;
    ival_rd_o[TGL_BIT]         = fit_q;
  end

  assign fi_o  = fi_q;
  assign ldp_o = ldp_q;
  assign fit_o = fit_q;
  assign ps_o  = ps_q;
endmodule

// File: rtl/ft_remain.sv
module ft_remain #(
  parameter int unsigned FI_W = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            tick_i,
  input  logic [FI_W-1:0] fi_i,
  input  logic            fit_i,
  input  logic [FI_W-1:0] ps_i,
  output logic [FI_W-1:0] remain_o,
  output logic            tgl_o,
  output logic            frame_end_o,
  output logic            ps_hit_o
);
  logic [FI_W-1:0] remain_q;
  logic            tgl_q, ps_hit_q;
  logic            at_zero;

  assign at_zero     = (remain_q == '0);
  assign frame_end_o = tick_i & at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      tgl_q    <= 1'b0;
    end else if (load_i || frame_end_o) begin
      remain_q <= fi_i;
      tgl_q    <= fit_i;
    end else if (tick_i) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  // Crossing from ps to ps-1; a zero threshold is never crossed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ps_hit_q <= 1'b0;
    else         ps_hit_q <= tick_i && !at_zero && (remain_q == ps_i);
  end

  assign remain_o = remain_q;
  assign tgl_o    = tgl_q;
  assign ps_hit_o = ps_hit_q;
endmodule

// File: rtl/ft_fnum.sv
module ft_fnum #(
  parameter int unsigned FN_W  = 16,
  parameter int unsigned LDP_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_end_i,
  input  logic             load_i,
  input  logic [LDP_W-1:0] ldp_i,
  output logic [FN_W-1:0]  fn_o,
  output logic [LDP_W-1:0] ldp_o,
  output logic             sof_o,
  output logic             fno_o
);
  localparam int unsigned MSB = FN_W - 1;

  logic [FN_W-1:0]  fn_q, fn_nxt;
  logic [LDP_W-1:0] ldp_q;
  logic             sof_q, fno_q;

  assign fn_nxt = fn_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_q  <= '0;
      sof_q <= 1'b0;
      fno_q <= 1'b0;
    end else begin
      sof_q <= frame_end_i;
      fno_q <= frame_end_i && (fn_nxt[MSB] != fn_q[MSB]);
      if (frame_end_i) fn_q <= fn_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ldp_q <= '0;
    else if (frame_end_i || load_i)  ldp_q <= ldp_i;
  end

  assign fn_o  = fn_q;
  assign ldp_o = ldp_q;
  assign sof_o = sof_q;
  assign fno_o = fno_q;
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import usb_ft_pkg::*;
#(
  parameter int unsigned FI_W     = 14,
  parameter int unsigned FN_W     = 16,
  parameter int unsigned FI_RESET = 11999
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic [1:0]       state_i,
  input  logic             ival_we_i,
  input  logic             pstart_we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      ival_o,
  output logic [FI_W-1:0]  pstart_o,
  output logic [FI_W-1:0]  remain_o,
  output logic             remain_tgl_o,
  output logic [FN_W-1:0]  frame_num_o,
  output logic [FI_W-1:0]  ldp_o,
  output logic             sof_o,
  output logic             fno_o,
  output logic             pstart_hit_o
);
  logic            op, op_q, enter, tick, frame_end, fit;
  logic [FI_W-1:0] fi, ldp_cfg, ps;

  assign op    = (fstate_e'(state_i) == FS_OPER);
  assign enter = op & ~op_q;
  assign tick  = op & bit_en_i & ~enter;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) op_q <= 1'b0;
    else         op_q <= op;
  end

  ft_regs #(.FI_W(FI_W), .FI_RESET(FI_RESET)) u_regs (
    .clk_i, .rst_ni, .ival_we_i, .pstart_we_i, .wdata_i,
    .fi_o(fi), .ldp_o(ldp_cfg), .fit_o(fit), .ps_o(ps), .ival_rd_o(ival_o)
  );

  ft_remain #(.FI_W(FI_W)) u_remain (
    .clk_i, .rst_ni, .load_i(enter), .tick_i(tick), .fi_i(fi), .fit_i(fit),
    .ps_i(ps), .remain_o, .tgl_o(remain_tgl_o), .frame_end_o(frame_end),
    .ps_hit_o(pstart_hit_o)
  );

  ft_fnum #(.FN_W(FN_W), .LDP_W(FI_W)) u_fnum (
    .clk_i, .rst_ni, .frame_end_i(frame_end), .load_i(enter), .ldp_i(ldp_cfg),
    .fn_o(frame_num_o), .ldp_o, .sof_o, .fno_o
  );

  assign pstart_o = ps;
endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk #(
  parameter int unsigned FI_W = 14,
  parameter int unsigned FN_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bit_en_i,
  input logic [1:0]      state_i,
  input logic [31:0]     ival_o,
  input logic [FI_W-1:0] pstart_o,
  input logic [FI_W-1:0] remain_o,
  input logic            remain_tgl_o,
  input logic [FN_W-1:0] frame_num_o,
  input logic            sof_o,
  input logic            fno_o,
  input logic            pstart_hit_o
);
  p_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && bit_en_i && state_i == 2'b10 && $past(state_i) == 2'b10
     && remain_o != '0) |=> remain_o == $past(remain_o) - 1'b1);

  p_sof_fn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> frame_num_o == $past(frame_num_o) + 1'b1);

  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (remain_o == $past(ival_o[FI_W-1:0]) && remain_tgl_o == $past(ival_o[31])));

  p_fno_sof_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fno_o |-> sof_o);

  p_fno_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> fno_o == (frame_num_o[FN_W-1] != $past(frame_num_o[FN_W-1])));

  p_pstart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstart_hit_o |-> ($past(remain_o) == $past(pstart_o) && remain_o == $past(remain_o) - 1'b1));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != 2'b10) |=> ($stable(frame_num_o) && !sof_o && !fno_o && !pstart_hit_o));
endmodule

bind usb_frame_timer usb_frame_timer_chk #(.FI_W(FI_W), .FN_W(FN_W)) u_chk (
  .clk_i, .rst_ni, .bit_en_i, .state_i, .ival_o, .pstart_o, .remain_o,
  .remain_tgl_o, .frame_num_o, .sof_o, .fno_o, .pstart_hit_o
);

// File: tb/tb_usb_frame_timer.sv
module tb_usb_frame_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic [1:0]  state = 2'b00;
  logic        ival_we = 1'b0, pstart_we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] ival;
  logic [13:0] pstart, remain, ldp;
  logic        tgl, sof, fno, hit;
  logic [15:0] fn;

  int errors = 0;
  int checks = 0;

  localparam logic [1:0] ST_OPER = 2'b10;
  localparam logic [1:0] ST_SUSP = 2'b11;

  always #2 clk = ~clk;

  usb_frame_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .state_i(state),
    .ival_we_i(ival_we), .pstart_we_i(pstart_we), .wdata_i(wdata),
    .ival_o(ival), .pstart_o(pstart), .remain_o(remain), .remain_tgl_o(tgl),
    .frame_num_o(fn), .ldp_o(ldp), .sof_o(sof), .fno_o(fno), .pstart_hit_o(hit)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One clock; inputs change and outputs are sampled at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ival(input logic [31:0] d);
    wdata = d; ival_we = 1'b1; step(); ival_we = 1'b0;
  endtask

  task automatic wr_ps(input logic [31:0] d);
    wdata = d; pstart_we = 1'b1; step(); pstart_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; state = 2'b00; bit_en = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    chk(remain == 0 && tgl == 0 && fn == 0 && ldp == 0, "R1 counters", {remain, fn}, 0);
    chk(!sof && !fno && !hit && pstart == 0, "R1 pulses", {sof, fno, hit}, 0);
    chk(ival == 32'h0000_2EDF, "R1 interval", ival, 32'h2EDF);
  endtask

  task automatic t_regs();
    wr_ival(32'hFFFF_FFFF);
    chk(ival == 32'hBFFF_3FFF, "R2 interval fields", ival, 32'hBFFF_3FFF);
    wr_ps(32'hFFFF_C003);
    chk(pstart == 14'd3, "R2 periodic start", pstart, 3);
    chk(remain == 0 && fn == 0, "R10 regs idle", remain, 0);
  endtask

  task automatic t_frames();
    int gap;
    wr_ival(32'h8123_0005);
    chk(ival == 32'h8123_0005, "R2 readback", ival, 32'h81230005);
    state = ST_OPER; bit_en = 1'b0; step();
    chk(remain == 5 && tgl == 1, "R3 entry load", {tgl, remain}, {1'b1, 14'd5});
    chk(fn == 0 && !sof && ldp == 14'h123, "R3 no frame event", {sof, fn}, 0);
    bit_en = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      step();
      chk(remain == 14'(5 - k), "R4 decrement", remain, 5 - k);
      chk(hit == (k == 3), "R9 threshold pulse", hit, (k == 3));
      chk(!sof, "R6 no early sof", sof, 0);
    end
    step();
    chk(remain == 5 && tgl == 1 && fn == 1, "R5 reload", {tgl, remain, fn}, {1'b1, 14'd5, 16'd1});
    chk(sof && !fno && ldp == 14'h123, "R5 sof", {sof, fno}, 2'b10);
    gap = 0;
    do begin step(); gap++; end while (!sof && gap < 20);
    chk(gap == 6, "R6 frame period", gap, 6);
    chk(fn == 2, "R5 fn advance", fn, 2);
  endtask

  task automatic t_midwrite();
    step(); step();
    chk(remain == 3, "R11 pre-write", remain, 3);
    wdata = 32'h0007_0002; ival_we = 1'b1; step(); ival_we = 1'b0;
    chk(remain == 2 && tgl == 1, "R11 count unaffected", {tgl, remain}, {1'b1, 14'd2});
    step(); step();
    chk(remain == 0 && tgl == 1, "R11 old toggle kept", {tgl, remain}, {1'b1, 14'd0});
    step();
    chk(remain == 2 && tgl == 0 && sof && ldp == 14'd7, "R11 new interval", {tgl, remain}, 14'd2);
  endtask

  task automatic t_hold();
    logic [13:0] r0;
    logic [15:0] f0;
    int pulses;
    bit_en = 1'b0;
    r0 = remain; f0 = fn; pulses = 0;
    for (int k = 0; k < 4; k++) begin
      step(); pulses += int'(sof) + int'(hit) + int'(fno);
    end
    chk(remain == r0 && fn == f0 && pulses == 0, "R10 enable low hold", remain, r0);
    state = ST_SUSP; bit_en = 1'b1;
    for (int k = 0; k < 20; k++) begin
      step(); pulses += int'(sof) + int'(hit) + int'(fno);
    end
    chk(remain == r0 && fn == f0 && tgl == 0, "R10 suspend hold", {fn, remain}, {f0, r0});
    chk(pulses == 0, "R10 no pulses", pulses, 0);
    state = ST_OPER; step();
    chk(remain == 2 && fn == f0 && !sof, "R3 re-entry load", {fn, remain}, {f0, 14'd2});
  endtask

  task automatic t_wrap();
    int fno_cnt, hit_cnt, fno_bad, sof_bad;
    do_reset();
    wr_ival(32'h0000_0000);
    state = ST_OPER; bit_en = 1'b0; step();
    bit_en = 1'b1;
    fno_cnt = 0; hit_cnt = 0; fno_bad = 0; sof_bad = 0;
    for (int i = 1; i <= 65536; i++) begin
      step();
      if (!sof) sof_bad++;
      if (fno) fno_cnt++;
      if (hit) hit_cnt++;
      if (fno != (fn == 16'h8000 || fn == 16'h0000)) fno_bad++;
      if (i == 32768) chk(fn == 16'h8000 && fno, "R8 top bit rise", {fno, fn}, {1'b1, 16'h8000});
    end
    chk(fn == 16'h0000, "R7 rollover", fn, 0);
    chk(fno_cnt == 2 && fno_bad == 0, "R8 overflow count", fno_cnt, 2);
    chk(sof_bad == 0, "R6 one-tick frames", sof_bad, 0);
    chk(hit_cnt == 0, "R9 zero threshold", hit_cnt, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_regs();
    t_frames();
    t_midwrite();
    t_hold();
    t_wrap();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule